// File: doc/BRIEF.md
# Effective Address Mode Decoder

This block turns the 6-bit mode/register field of an instruction, together with the operand size in bytes, into a decoded operand-address record. The record carries a register number, a set of mode flags, a 32-bit displacement or absolute address, and up to three 32-bit words of immediate data. Many addressing modes need extension words that follow the opcode in the instruction stream. The decoder requests those 16-bit words one at a time from an instruction-word fetch port. It then sign-extends or concatenates them according to the mode and the operand size.

A decode starts with a one-cycle `start_i` pulse. The caller supplies the byte offset at which the extension words begin, so the decoder can be chained after whatever consumed the opcode word. Each request shows the current offset. When the decode ends, `done_o` pulses for one cycle, with an error code and the final offset. Indexed modes only classify the field and set their flag; the indexed extension word is left to a separate block. The decoder performs no operand data access.

Top module: `ea_mode_decoder`

## Requirements
- R1: Field bits 5:3 select the mode and bits 2:0 the register. Mode 0 gives register number 0..7 and mode 1 gives 8 plus the register bits; both set only the direct flag. Modes 2 to 6 give 8 plus the register bits. Mode 2 sets indirect, mode 3 sets indirect and postincrement, mode 4 sets indirect and predecrement, mode 5 sets indirect and offset, and mode 6 sets indirect and indexed. Flag bit positions: direct 0, indirect 1, postincrement 2, predecrement 3, offset 4, indexed 5, absolute 6, PC-relative 7, immediate 8.
- R2: In mode 7 the register number output equals the sub-mode. Sub-mode 0 sets absolute with one word, and sub-mode 1 sets absolute with two words. Sub-mode 2 sets PC-relative and offset with one word. Sub-mode 3 sets PC-relative and indexed with no word. Sub-mode 4 sets immediate.
- R3: Mode 7 sub-modes 5, 6 and 7 end the decode with error code 1 (illegal), without any fetch request. The flags, register number, displacement and immediate outputs are then zero, and the offset output equals the start offset.
- R4: A one-word displacement or address is sign-extended from bit 15 to 32 bits, and the offset output ends 2 above the start offset.
- R5: A two-word absolute address takes the first fetched word as bits 31:16 and the second as bits 15:0, and the offset output ends 4 above the start offset.
- R6: For an immediate operand of size 1, the first word's bit 7 is sign-extended from its low byte. For size 2, bit 15 is extended. Both use a single fetch.
- R7: For an immediate operand, the number of words is 1 for any nonzero size, plus 1 for sizes above 2, plus 2 for sizes above 4, plus 2 for sizes above 8. Immediate word k (bits 32k+31:32k) is the pair of fetched words 2k, 2k+1, with the earlier word high. Size 0 fetches nothing and returns zero data.
- R8: A fetch answered with the fault flag ends the decode in that cycle with error code 2 (fault). No further request is made, all record fields are zero, and the offset output counts only the words accepted before the fault.
- R9: Each request shows on `fetch_ofs_o` the start offset plus 2 for every word already accepted in this decode.
- R10: `done_o` is a single-cycle pulse. It comes in the cycle after the last word is accepted, or in the cycle after start when no word is needed. After reset no request or done is active and the error code is 0.
- R11: A start pulse while a decode is in progress is ignored; the running decode finishes with its own result.
- R12: Register-direct, plain indirect, postincrement, predecrement and both indexed modes finish with no fetch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a decode (ignored while busy) |
| modreg_i | input | 6 | Mode (5:3) and register (2:0) field |
| opsize_i | input | SIZE_W | Operand size in bytes |
| adv_init_i | input | ADV_W | Byte offset of the first extension word |
| fetch_req_o | output | 1 | Extension-word request valid |
| fetch_ofs_o | output | ADV_W | Byte offset of the requested word |
| fetch_ack_i | input | 1 | Request accepted; data or fault valid this cycle |
| fetch_data_i | input | 16 | Fetched extension word |
| fetch_err_i | input | 1 | Fetch fault with this acknowledge |
| done_o | output | 1 | Decode finished (one-cycle pulse) |
| err_o | output | 2 | 0 ok, 1 illegal mode, 2 fetch fault |
| regnum_o | output | 4 | Decoded register number |
| flags_o | output | 9 | Mode flags |
| disp_o | output | 32 | Displacement or absolute address |
| imm_o | output | 32*IMM_WORDS | Immediate data, word k at bits 32k+31:32k |
| adv_o | output | ADV_W | Byte offset after the decode |

## Verification
Two things can land in the same cycle: a new start pulse, and the acceptance of an extension word for the decode already running. The bench raises `start_i` with an illegal field in the very cycle a request is acknowledged. It then judges the result by the running decode's value, flags and offset, with no illegal error. The second overlap is a fault acknowledge on the last word a decode needs. There the bench expects the fault code, zeroed fields, and an offset that excludes the faulting word, rather than a normal completion.

// File: rtl/ea_dec_pkg.sv
package ea_dec_pkg;

    localparam int FLAG_W    = 9;
    localparam int F_DIRECT  = 0;
    localparam int F_INDIR   = 1;
    localparam int F_POSTINC = 2;
    localparam int F_PREDEC  = 3;
    localparam int F_OFFSET  = 4;
    localparam int F_INDEXED = 5;
    localparam int F_ABS     = 6;
    localparam int F_PCREL   = 7;
    localparam int F_IMMED   = 8;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_ILLEGAL = 2'd1,
        ERR_FAULT   = 2'd2
    } ea_err_e;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_DISP16 = 2'd1,
        FK_ABS32  = 2'd2,
        FK_IMM    = 2'd3
    } fetch_kind_e;

endpackage

// File: rtl/ea_mode_classify.sv
module ea_mode_classify
    import ea_dec_pkg::*;
#(
    parameter int SIZE_W = 4,
    parameter int CNT_W  = 3
) (
    input  logic [5:0]        modreg_i,
    input  logic [SIZE_W-1:0] opsize_i,
    output logic [3:0]        regnum_o,
    output logic [FLAG_W-1:0] flags_o,
    output fetch_kind_e       kind_o,
    output logic [CNT_W-1:0]  nwords_o,
    output logic              illegal_o
);

    logic [2:0]       rsel;
    logic [CNT_W-1:0] imm_words;

    assign rsel = modreg_i[2:0];

    // word count for an immediate operand grows in steps with the size
    always_comb begin
        imm_words = '0;
        if (opsize_i > SIZE_W'(0)) imm_words = imm_words + CNT_W'(1);
        if (opsize_i > SIZE_W'(2)) imm_words = imm_words + CNT_W'(1);
        if (opsize_i > SIZE_W'(4)) imm_words = imm_words + CNT_W'(2);
        if (opsize_i > SIZE_W'(8)) imm_words = imm_words + CNT_W'(2);
    end

    always_comb begin
        regnum_o  = {1'b1, rsel};
        flags_o   = '0;
        kind_o    = FK_NONE;
        nwords_o  = '0;
        illegal_o = 1'b0;
        unique case (modreg_i[5:3])
            3'd0: begin
                regnum_o          = {1'b0, rsel};
                flags_o[F_DIRECT] = 1'b1;
            end
            3'd1: flags_o[F_DIRECT] = 1'b1;
            3'd2: flags_o[F_INDIR]  = 1'b1;
            3'd3: begin
                flags_o[F_INDIR]   = 1'b1;
                flags_o[F_POSTINC] = 1'b1;
            end
            3'd4: begin
                flags_o[F_INDIR]  = 1'b1;
                flags_o[F_PREDEC] = 1'b1;
            end
            3'd5: begin
                flags_o[F_INDIR]  = 1'b1;
                flags_o[F_OFFSET] = 1'b1;
                kind_o            = FK_DISP16;
                nwords_o          = CNT_W'(1);
            end
            3'd6: begin
                flags_o[F_INDIR]   = 1'b1;
                flags_o[F_INDEXED] = 1'b1;
            end
            default: begin
                regnum_o = {1'b0, rsel};
                unique case (rsel)
                    3'd0: begin
                        flags_o[F_ABS] = 1'b1;
                        kind_o         = FK_DISP16;
                        nwords_o       = CNT_W'(1);
                    end
                    3'd1: begin
                        flags_o[F_ABS] = 1'b1;
                        kind_o         = FK_ABS32;
                        nwords_o       = CNT_W'(2);
                    end
                    3'd2: begin
                        flags_o[F_PCREL]  = 1'b1;
                        flags_o[F_OFFSET] = 1'b1;
                        kind_o            = FK_DISP16;
                        nwords_o          = CNT_W'(1);
                    end
                    3'd3: begin
                        flags_o[F_PCREL]   = 1'b1;
                        flags_o[F_INDEXED] = 1'b1;
                    end
                    3'd4: begin
                        flags_o[F_IMMED] = 1'b1;
                        kind_o           = FK_IMM;
                        nwords_o         = imm_words;
                    end
                    default: illegal_o = 1'b1;
                endcase
            end
        endcase
    end

    // the direct flag never combines with any other mode flag
    always_comb begin
        AST_DIRECT_EXCLUSIVE: assert (!(flags_o[F_DIRECT] && (|flags_o[FLAG_W-1:1]))); // R1
    end

endmodule

// File: rtl/ea_ext_assemble.sv
module ea_ext_assemble
    import ea_dec_pkg::*;
#(
    parameter int SIZE_W    = 4,
    parameter int CNT_W     = 3,
    parameter int IMM_WORDS = 3,
    localparam int MAX_WORDS = 2 * IMM_WORDS
) (
    input  logic [16*MAX_WORDS-1:0] words_i,
    input  fetch_kind_e             kind_i,
    input  logic [SIZE_W-1:0]       opsize_i,
    input  logic [CNT_W-1:0]        nwords_i,
    output logic [31:0]             disp_o,
    output logic [32*IMM_WORDS-1:0] imm_o
);

    logic [15:0] w0;
    logic [15:0] w1;
    logic [31:0] imm_first;

    assign w0 = words_i[15:0];
    assign w1 = words_i[31:16];

    always_comb begin
        unique case (kind_i)
            FK_DISP16: disp_o = {{16{w0[15]}}, w0};
            FK_ABS32:  disp_o = {w0, w1};
            default:   disp_o = '0;
        endcase
    end

    always_comb begin
        if (nwords_i >= CNT_W'(2))
            imm_first = {w0, w1};
        else if (opsize_i == SIZE_W'(1))
            imm_first = {{24{w0[7]}}, w0[7:0]};
        else if (opsize_i == SIZE_W'(2))
            imm_first = {{16{w0[15]}}, w0};
        else
            imm_first = {16'h0000, w0};
    end

    assign imm_o[31:0] = (kind_i == FK_IMM) ? imm_first : 32'h0;

    for (genvar k = 1; k < IMM_WORDS; k++) begin : g_imm_pair
        assign imm_o[32*k +: 32] =
            ((kind_i == FK_IMM) && (int'(nwords_i) > 2*k))
                ? {words_i[16*(2*k) +: 16], words_i[16*(2*k+1) +: 16]}
                : 32'h0;
    end

endmodule

// File: rtl/ea_mode_decoder.sv
module ea_mode_decoder
    import ea_dec_pkg::*;
#(
    parameter int SIZE_W    = 4,
    parameter int ADV_W     = 8,
    parameter int IMM_WORDS = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [5:0]              modreg_i,
    input  logic [SIZE_W-1:0]       opsize_i,
    input  logic [ADV_W-1:0]        adv_init_i,
    output logic                    fetch_req_o,
    output logic [ADV_W-1:0]        fetch_ofs_o,
    input  logic                    fetch_ack_i,
    input  logic [15:0]             fetch_data_i,
    input  logic                    fetch_err_i,
    output logic                    done_o,
    output logic [1:0]              err_o,
    output logic [3:0]              regnum_o,
    output logic [8:0]              flags_o,
    output logic [31:0]             disp_o,
    output logic [32*IMM_WORDS-1:0] imm_o,
    output logic [ADV_W-1:0]        adv_o
);

    localparam int MAX_WORDS = 2 * IMM_WORDS;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam int BUF_W     = 16 * MAX_WORDS;
    localparam int IMM_W     = 32 * IMM_WORDS;

    typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  need;
        fetch_kind_e       kind;
        logic [SIZE_W-1:0] size;
        logic [3:0]        regnum;
        logic [FLAG_W-1:0] flags;
        logic [ADV_W-1:0]  adv;
        logic [BUF_W-1:0]  wbuf;
        logic              done;
        ea_err_e           err;
        logic [3:0]        r_regnum;
        logic [FLAG_W-1:0] r_flags;
        logic [31:0]       r_disp;
        logic [IMM_W-1:0]  r_imm;
        logic [ADV_W-1:0]  r_adv;
    } dec_state_t;

    dec_state_t state_q, state_d;

    logic [3:0]        cls_regnum;
    logic [FLAG_W-1:0] cls_flags;
    fetch_kind_e       cls_kind;
    logic [CNT_W-1:0]  cls_nwords;
    logic              cls_illegal;

    logic              fire;
    logic [BUF_W-1:0]  buf_upd;
    logic [31:0]       asm_disp;
    logic [IMM_W-1:0]  asm_imm;

    ea_mode_classify #(
        .SIZE_W (SIZE_W),
        .CNT_W  (CNT_W)
    ) u_classify (
        .modreg_i  (modreg_i),
        .opsize_i  (opsize_i),
        .regnum_o  (cls_regnum),
        .flags_o   (cls_flags),
        .kind_o    (cls_kind),
        .nwords_o  (cls_nwords),
        .illegal_o (cls_illegal)
    );

    assign fire = (state_q.st == ST_FETCH) && fetch_ack_i;

    always_comb begin
        buf_upd = state_q.wbuf;
        if (fire)
            buf_upd[16*state_q.cnt +: 16] = fetch_data_i;
    end

    ea_ext_assemble #(
        .SIZE_W    (SIZE_W),
        .CNT_W     (CNT_W),
        .IMM_WORDS (IMM_WORDS)
    ) u_assemble (
        .words_i  (buf_upd),
        .kind_i   (state_q.kind),
        .opsize_i (state_q.size),
        .nwords_i (state_q.need),
        .disp_o   (asm_disp),
        .imm_o    (asm_imm)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        unique case (state_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    state_d.adv    = adv_init_i;
                    state_d.cnt    = '0;
                    state_d.need   = cls_nwords;
                    state_d.kind   = cls_kind;
                    state_d.size   = opsize_i;
                    state_d.regnum = cls_regnum;
                    state_d.flags  = cls_flags;
                    state_d.wbuf   = '0;
                    if (cls_illegal) begin
                        state_d.done     = 1'b1;
                        state_d.err      = ERR_ILLEGAL;
                        state_d.r_regnum = '0;
                        state_d.r_flags  = '0;
                        state_d.r_disp   = '0;
                        state_d.r_imm    = '0;
                        state_d.r_adv    = adv_init_i;
                    end else if (cls_nwords == '0) begin
                        state_d.done     = 1'b1;
                        state_d.err      = ERR_NONE;
                        state_d.r_regnum = cls_regnum;
                        state_d.r_flags  = cls_flags;
                        state_d.r_disp   = '0;
                        state_d.r_imm    = '0;
                        state_d.r_adv    = adv_init_i;
                    end else begin
                        state_d.st = ST_FETCH;
                    end
                end
            end
            default: begin
                if (fetch_ack_i) begin
                    if (fetch_err_i) begin
                        state_d.st       = ST_IDLE;
                        state_d.done     = 1'b1;
                        state_d.err      = ERR_FAULT;
                        state_d.r_regnum = '0;
                        state_d.r_flags  = '0;
                        state_d.r_disp   = '0;
                        state_d.r_imm    = '0;
                        state_d.r_adv    = state_q.adv;
                    end else begin
                        state_d.adv  = state_q.adv + ADV_W'(2);
                        state_d.wbuf = buf_upd;
                        state_d.cnt  = state_q.cnt + CNT_W'(1);
                        if (state_q.cnt == state_q.need - CNT_W'(1)) begin
                            state_d.st       = ST_IDLE;
                            state_d.done     = 1'b1;
                            state_d.err      = ERR_NONE;
                            state_d.r_regnum = state_q.regnum;
                            state_d.r_flags  = state_q.flags;
                            state_d.r_disp   = asm_disp;
                            state_d.r_imm    = asm_imm;
                            state_d.r_adv    = state_q.adv + ADV_W'(2);
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.st   <= ST_IDLE;
            state_q.kind <= FK_NONE;
            state_q.err  <= ERR_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch_req_o = (state_q.st == ST_FETCH);
    assign fetch_ofs_o = state_q.adv;
    assign done_o      = state_q.done;
    assign err_o       = state_q.err;
    assign regnum_o    = state_q.r_regnum;
    assign flags_o     = state_q.r_flags;
    assign disp_o      = state_q.r_disp;
    assign imm_o       = state_q.r_imm;
    assign adv_o       = state_q.r_adv;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_ILLEGAL_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !fetch_req_o && (modreg_i[5:3] == 3'd7) && (modreg_i[2:0] > 3'd4))
        |=> (done_o && (err_o == 2'd1) && !fetch_req_o)); // R3

    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_ack_i && fetch_err_i)
        |=> (done_o && (err_o == 2'd2) && !fetch_req_o && (flags_o == '0))); // R8

    AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_ack_i && !fetch_err_i && fetch_req_o)
        |=> (fetch_ofs_o == $past(fetch_ofs_o) + ADV_W'(2))); // R9

    AST_ERR_ZERO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (err_o != 2'd0)) |-> ((flags_o == '0) && (disp_o == '0))); // R3

endmodule

// File: tb/tb_ea_mode_decoder.sv
module tb_ea_mode_decoder;

    localparam int SIZE_W = 4;
    localparam int ADV_W  = 8;
    localparam int IMMW   = 3;

    localparam logic [8:0] FL_DIR  = 9'h001;
    localparam logic [8:0] FL_IND  = 9'h002;
    localparam logic [8:0] FL_POST = 9'h004;
    localparam logic [8:0] FL_PRE  = 9'h008;
    localparam logic [8:0] FL_OFS  = 9'h010;
    localparam logic [8:0] FL_IDX  = 9'h020;
    localparam logic [8:0] FL_ABS  = 9'h040;
    localparam logic [8:0] FL_PC   = 9'h080;
    localparam logic [8:0] FL_IMM  = 9'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [5:0] modreg = '0;
    logic [SIZE_W-1:0] opsize = '0;
    logic [ADV_W-1:0] adv_init = '0;
    logic fetch_req;
    logic [ADV_W-1:0] fetch_ofs;
    logic ack = 1'b0;
    logic [15:0] wdata = '0;
    logic ferr = 1'b0;
    logic done;
    logic [1:0] err;
    logic [3:0] regnum;
    logic [8:0] flags;
    logic [31:0] disp;
    logic [32*IMMW-1:0] imm;
    logic [ADV_W-1:0] adv;

    int total = 0;
    int bad = 0;
    int served;
    int stall;
    logic [15:0] wq [6];

    always #10 clk = ~clk;

    ea_mode_decoder #(.SIZE_W(SIZE_W), .ADV_W(ADV_W), .IMM_WORDS(IMMW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .modreg_i(modreg),
        .opsize_i(opsize), .adv_init_i(adv_init), .fetch_req_o(fetch_req),
        .fetch_ofs_o(fetch_ofs), .fetch_ack_i(ack), .fetch_data_i(wdata),
        .fetch_err_i(ferr), .done_o(done), .err_o(err), .regnum_o(regnum),
        .flags_o(flags), .disp_o(disp), .imm_o(imm), .adv_o(adv)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // start one decode and serve its requests from wq; fault_at<0 means no fault
    task automatic do_decode(input logic [5:0] mr, input logic [3:0] sz,
                             input logic [7:0] ai, input int fault_at, input bit poke);
        int cyc;
        @(negedge clk);
        modreg = mr; opsize = sz; adv_init = ai; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        served = 0; stall = 0; cyc = 0;
        while (!done && cyc < 40) begin
            if (fetch_req) begin
                chk("R9", "request offset", 128'(fetch_ofs), 128'(ai + 8'(2*served)));
                ack = 1'b1; wdata = wq[served]; ferr = (served == fault_at);
                if (poke && served == 0) begin
                    start = 1'b1; modreg = 6'o77;
                end
                @(negedge clk);
                ack = 1'b0; ferr = 1'b0; start = 1'b0; served++;
            end else begin
                stall++;
                @(negedge clk);
            end
            cyc++;
        end
        chk("R10", "done latency stall cycles", 128'(stall), 128'(0));
        @(negedge clk);
        chk("R10", "done is one pulse", 128'(done), 128'(0));
    endtask

    task automatic t_reset();
        chk("R10", "reset req", 128'(fetch_req), 128'(0));
        chk("R10", "reset done", 128'(done), 128'(0));
        chk("R10", "reset err", 128'(err), 128'(0));
    endtask

    task automatic t_regs();
        do_decode(6'o05, 4'd4, 8'h02, -1, 1'b0);
        chk("R1", "mode0 regnum", 128'(regnum), 128'(5));
        chk("R1", "mode0 flags", 128'(flags), 128'(FL_DIR));
        chk("R12", "mode0 no fetch", 128'(served), 128'(0));
        do_decode(6'o13, 4'd4, 8'h02, -1, 1'b0);
        chk("R1", "mode1 regnum", 128'(regnum), 128'(11));
        chk("R1", "mode1 flags", 128'(flags), 128'(FL_DIR));
        do_decode(6'o27, 4'd4, 8'h02, -1, 1'b0);
        chk("R1", "mode2 regnum", 128'(regnum), 128'(15));
        chk("R1", "mode2 flags", 128'(flags), 128'(FL_IND));
        do_decode(6'o31, 4'd2, 8'h02, -1, 1'b0);
        chk("R1", "mode3 flags", 128'(flags), 128'(FL_IND | FL_POST));
        chk("R12", "mode3 no fetch", 128'(served), 128'(0));
        do_decode(6'o42, 4'd2, 8'h02, -1, 1'b0);
        chk("R1", "mode4 regnum", 128'(regnum), 128'(10));
        chk("R1", "mode4 flags", 128'(flags), 128'(FL_IND | FL_PRE));
        do_decode(6'o64, 4'd4, 8'h02, -1, 1'b0);
        chk("R1", "mode6 flags", 128'(flags), 128'(FL_IND | FL_IDX));
        chk("R12", "mode6 no fetch", 128'(served), 128'(0));
        chk("R12", "mode6 adv", 128'(adv), 128'(8'h02));
    endtask

    task automatic t_disp();
        wq[0] = 16'h8001;
        do_decode(6'o53, 4'd4, 8'h04, -1, 1'b0);
        chk("R1", "mode5 flags", 128'(flags), 128'(FL_IND | FL_OFS));
        chk("R4", "mode5 disp", 128'(disp), 128'(32'hFFFF_8001));
        chk("R4", "mode5 adv", 128'(adv), 128'(8'h06));
        chk("R4", "mode5 words", 128'(served), 128'(1));
        wq[0] = 16'h7FFE;
        do_decode(6'o70, 4'd4, 8'h02, -1, 1'b0);
        chk("R2", "abs word regnum", 128'(regnum), 128'(0));
        chk("R2", "abs word flags", 128'(flags), 128'(FL_ABS));
        chk("R4", "abs word value", 128'(disp), 128'(32'h0000_7FFE));
        wq[0] = 16'hFF00;
        do_decode(6'o72, 4'd4, 8'h02, -1, 1'b0);
        chk("R2", "pc disp flags", 128'(flags), 128'(FL_PC | FL_OFS));
        chk("R2", "pc disp regnum", 128'(regnum), 128'(2));
        chk("R4", "pc disp value", 128'(disp), 128'(32'hFFFF_FF00));
        do_decode(6'o73, 4'd4, 8'h02, -1, 1'b0);
        chk("R2", "pc indexed flags", 128'(flags), 128'(FL_PC | FL_IDX));
        chk("R12", "pc indexed no fetch", 128'(served), 128'(0));
    endtask

    task automatic t_abs_long();
        wq[0] = 16'h1234; wq[1] = 16'hABCD;
        do_decode(6'o71, 4'd4, 8'h10, -1, 1'b0);
        chk("R2", "abs long flags", 128'(flags), 128'(FL_ABS));
        chk("R5", "abs long value", 128'(disp), 128'(32'h1234_ABCD));
        chk("R5", "abs long adv", 128'(adv), 128'(8'h14));
        chk("R5", "abs long err", 128'(err), 128'(0));
    endtask

    task automatic t_illegal();
        for (int s = 5; s < 8; s++) begin
            do_decode({3'd7, 3'(s)}, 4'd4, 8'h06, -1, 1'b0);
            chk("R3", "illegal err", 128'(err), 128'(1));
            chk("R3", "illegal no fetch", 128'(served), 128'(0));
            chk("R3", "illegal flags", 128'(flags), 128'(0));
            chk("R3", "illegal adv", 128'(adv), 128'(8'h06));
        end
    endtask

    task automatic t_imm_short();
        wq[0] = 16'h1280;
        do_decode(6'o74, 4'd1, 8'h02, -1, 1'b0);
        chk("R2", "imm flags", 128'(flags), 128'(FL_IMM));
        chk("R6", "imm byte neg", 128'(imm), 128'(96'hFFFF_FF80));
        chk("R6", "imm byte words", 128'(served), 128'(1));
        wq[0] = 16'hA07F;
        do_decode(6'o74, 4'd1, 8'h02, -1, 1'b0);
        chk("R6", "imm byte pos", 128'(imm), 128'(96'h0000_007F));
        wq[0] = 16'h8000;
        do_decode(6'o74, 4'd2, 8'h02, -1, 1'b0);
        chk("R6", "imm word neg", 128'(imm), 128'(96'hFFFF_8000));
        chk("R6", "imm word adv", 128'(adv), 128'(8'h04));
    endtask

    task automatic t_imm_long();
        wq[0] = 16'hDEAD; wq[1] = 16'hBEEF; wq[2] = 16'h0123;
        wq[3] = 16'h4567; wq[4] = 16'h89AB; wq[5] = 16'hCDEF;
        do_decode(6'o74, 4'd4, 8'h02, -1, 1'b0);
        chk("R7", "imm4 words", 128'(served), 128'(2));
        chk("R7", "imm4 value", 128'(imm), 128'(96'hDEAD_BEEF));
        do_decode(6'o74, 4'd8, 8'h02, -1, 1'b0);
        chk("R7", "imm8 words", 128'(served), 128'(4));
        chk("R7", "imm8 value", 128'(imm), 128'({32'h0, 32'h0123_4567, 32'hDEAD_BEEF}));
        do_decode(6'o74, 4'd12, 8'h02, -1, 1'b0);
        chk("R7", "imm12 words", 128'(served), 128'(6));
        chk("R7", "imm12 value", 128'(imm),
            128'({32'h89AB_CDEF, 32'h0123_4567, 32'hDEAD_BEEF}));
        chk("R7", "imm12 adv", 128'(adv), 128'(8'h0E));
        do_decode(6'o74, 4'd0, 8'h02, -1, 1'b0);
        chk("R7", "imm0 words", 128'(served), 128'(0));
        chk("R7", "imm0 value", 128'(imm), 128'(0));
    endtask

    task automatic t_fault();
        wq[0] = 16'h1234; wq[1] = 16'hABCD;
        do_decode(6'o71, 4'd4, 8'h20, 1, 1'b0);
        chk("R8", "fault on last word err", 128'(err), 128'(2));
        chk("R8", "fault words tried", 128'(served), 128'(2));
        chk("R8", "fault adv", 128'(adv), 128'(8'h22));
        chk("R8", "fault disp", 128'(disp), 128'(0));
        chk("R8", "fault flags", 128'(flags), 128'(0));
        do_decode(6'o74, 4'd12, 8'h20, 0, 1'b0);
        chk("R8", "fault first err", 128'(err), 128'(2));
        chk("R8", "fault first served", 128'(served), 128'(1));
        chk("R8", "fault first adv", 128'(adv), 128'(8'h20));
        chk("R8", "fault first imm", 128'(imm), 128'(0));
    endtask

    task automatic t_busy_start();
        wq[0] = 16'h00C0; wq[1] = 16'h0FFE;
        do_decode(6'o71, 4'd4, 8'h08, -1, 1'b1);
        chk("R11", "busy start err", 128'(err), 128'(0));
        chk("R11", "busy start value", 128'(disp), 128'(32'h00C0_0FFE));
        chk("R11", "busy start flags", 128'(flags), 128'(FL_ABS));
        chk("R11", "busy start adv", 128'(adv), 128'(8'h0C));
        @(negedge clk);
        chk("R11", "no decode after poke", 128'(fetch_req | done), 128'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_regs();
        t_disp();
        t_abs_long();
        t_illegal();
        t_imm_short();
        t_imm_long();
        t_fault();
        t_busy_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule